// File: doc/BRIEF.md
# ECC Error Capture and Logging Unit

This unit sits beside a memory controller's ECC checker and keeps a record of the first memory error it reports, so that software can later find out what failed and where. On each cycle the checker may raise an error strobe. The strobe comes with a correctable (single-bit) or uncorrectable (multi-bit) type indication, an 8-bit syndrome and the physical address of the failing access. The unit stores the syndrome and the 4-KB block number of the address, and it raises a status flag for the error type.

Once something is logged, the record is frozen. There is one exception: an uncorrectable error may replace a logged correctable one. Every other later error is dropped without trace until software clears the status flags. Software clears a flag by writing a one to its bit. Software reads the syndrome, the status and the address through a byte-wide register port. The read path is combinational, and writes are accepted one byte per cycle.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset the syndrome byte, the status byte and all four address bytes read as zero.
- R2: With both flags clear, a valid error is captured at the clock edge where its strobe is seen. Its syndrome and block number are readable from the next cycle. The flag for its type (status bit 0 for single-bit, bit 1 for multi-bit) is set.
- R3: While only the single-bit flag is set, a multi-bit error replaces the logged syndrome and block number and sets the multi-bit flag. The single-bit flag stays set.
- R4: While the multi-bit flag is set, or the single-bit flag is set and the new error is single-bit, a new error changes neither the log nor the flags.
- R5: The address register is read little-endian at offsets 0x8C to 0x8F. Bits 29:1 hold physical address bits 40:12. Bits 31:30 and bit 0 always read zero.
- R6: The syndrome reads at offset 0x86 and the status at 0x88. Every unmapped offset reads zero.
- R7: A write to 0x88 clears each flag whose data bit is one and leaves a flag whose data bit is zero unchanged. Capture is re-enabled only when both flags are clear.
- R8: If a clear write and a new error arrive in the same cycle, the clear is applied first. The new error is then judged against the remaining flags, and when it is captured its flag ends up set.
- R9: A strobe with neither type asserted is ignored. A strobe with both types asserted is handled as a multi-bit error.
- R10: Writes to the syndrome and address offsets have no effect on the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errStrobe | input | 1 | Error report from the ECC checker |
| errSingle | input | 1 | Reported error is single-bit (correctable) |
| errMulti | input | 1 | Reported error is multi-bit (uncorrectable) |
| errSyndrome | input | SYN_W (8) | Syndrome of the reported error |
| errAddr | input | PA_W (41) | Physical address of the failing access |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write byte offset |
| wrData | input | 8 | Register write data |
| rdAddr | input | 8 | Register read byte offset |
| rdData | output | 8 | Register read data (combinational) |

## Verification
The bench uses the default parameters: an 8-bit syndrome and a 41-bit physical address. With these values the 29-bit block number fills address bits 29:1 completely. An all-ones failing address therefore drives the top block bit into bit 29, next to the reserved bits 31:30. This lets the bench show that the reserved bits stay zero at both ends of the field. The directed scenarios cover every ordering of single-bit and multi-bit errors, partial and same-cycle clears, and malformed strobes. After each step, every readable byte is compared against a reference model.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 8;
  localparam logic [REG_AW-1:0] SYN_OFF = 8'h86;
  localparam logic [REG_AW-1:0] STS_OFF = 8'h88;
  localparam logic [REG_AW-1:0] EA_OFF  = 8'h8C;
  localparam int EA_BYTES = 4;
  localparam int BLK_SHIFT = 12;   // 4-KB granularity
  localparam int EA_FIELD_W = 29;  // bits 29:1 of the address register

  typedef struct packed {
    logic capture;                 // load syndrome and block number
  } logStrobe_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              errStrobe,
  input  logic              errSingle,
  input  logic              errMulti,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [REG_DW-1:0] wrData,
  output logStrobe_t        strobe,
  output logic              sbeFlag,
  output logic              mbeFlag
);
  logic evValid, evMulti, stsWr;
  logic sbeKeep, mbeKeep, lockedKeep;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData[REG_DW-1:2];

  // A strobe needs at least one type; multi-bit wins when both are given.
  assign evValid = errStrobe & (errSingle | errMulti);
  assign evMulti = errMulti;

  // Write-one-to-clear is applied before the new event is judged.
  assign stsWr      = wrEn && (wrAddr == STS_OFF);
  assign sbeKeep    = sbeFlag & ~(stsWr & wrData[0]);
  assign mbeKeep    = mbeFlag & ~(stsWr & wrData[1]);
  assign lockedKeep = sbeKeep | mbeKeep;

  always_comb begin
    strobe = '0;
    strobe.capture = evValid & (~lockedKeep | (evMulti & ~mbeKeep));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbeFlag <= 1'b0;
      mbeFlag <= 1'b0;
    end else begin
      sbeFlag <= sbeKeep | (strobe.capture & ~evMulti);
      mbeFlag <= mbeKeep | (strobe.capture &  evMulti);
    end
  end
endmodule

// File: rtl/ecc_log_dp.sv
module ecc_log_dp
  import ecc_log_pkg::*;
#(
  parameter int PA_W  = 41,
  parameter int SYN_W = 8,
  localparam int BLK_W = PA_W - BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobe_t        strobe,
  input  logic [SYN_W-1:0]  errSyndrome,
  input  logic [PA_W-1:0]   errAddr,
  input  logic              sbeFlag,
  input  logic              mbeFlag,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [REG_DW-1:0] rdData,
  output logic [SYN_W-1:0]  synLog,
  output logic [BLK_W-1:0]  blkLog
);
  logic [8*EA_BYTES-1:0] eaWord;
  logic [REG_DW-1:0]     laneData [EA_BYTES];
  logic [EA_BYTES-1:0]   laneHit;
  logic                  unusedLowAddr;

  assign unusedLowAddr = ^errAddr[BLK_SHIFT-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      synLog <= '0;
      blkLog <= '0;
    end else if (strobe.capture) begin
      synLog <= errSyndrome;
      blkLog <= errAddr[PA_W-1:BLK_SHIFT];
    end
  end

  // Reserved bits 31:30 and 0 stay zero; unused upper field bits too.
  always_comb begin
    eaWord = '0;
    eaWord[BLK_W:1] = blkLog;
  end

  for (genvar i = 0; i < EA_BYTES; i++) begin : gLane
    assign laneHit[i]  = (rdAddr == EA_OFF + REG_AW'(i));
    assign laneData[i] = eaWord[8*i +: 8];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == SYN_OFF) rdData[SYN_W-1:0] = synLog;
    if (rdAddr == STS_OFF) rdData[1:0] = {mbeFlag, sbeFlag};
    for (int i = 0; i < EA_BYTES; i++)
      if (laneHit[i]) rdData = laneData[i];
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int PA_W  = 41,
  parameter int SYN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errStrobe,
  input  logic              errSingle,
  input  logic              errMulti,
  input  logic [SYN_W-1:0]  errSyndrome,
  input  logic [PA_W-1:0]   errAddr,
  input  logic              wrEn,
  input  logic [7:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        rdAddr,
  output logic [7:0]        rdData
);
  localparam int BLK_W = PA_W - BLK_SHIFT;

  logStrobe_t       strobe;
  logic             sbeFlag, mbeFlag;
  logic [SYN_W-1:0] synLog;
  logic [BLK_W-1:0] blkLog;

  ecc_log_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .errStrobe(errStrobe), .errSingle(errSingle), .errMulti(errMulti),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .sbeFlag(sbeFlag), .mbeFlag(mbeFlag)
  );

  ecc_log_dp #(.PA_W(PA_W), .SYN_W(SYN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .errSyndrome(errSyndrome), .errAddr(errAddr),
    .sbeFlag(sbeFlag), .mbeFlag(mbeFlag),
    .rdAddr(rdAddr), .rdData(rdData),
    .synLog(synLog), .blkLog(blkLog)
  );
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk
  import ecc_log_pkg::*;
#(
  parameter int PA_W  = 41,
  parameter int SYN_W = 8,
  localparam int BLK_W = PA_W - BLK_SHIFT
) (
  input logic             clk,
  input logic             rstN,
  input logic             errStrobe,
  input logic             errSingle,
  input logic             errMulti,
  input logic [SYN_W-1:0] errSyndrome,
  input logic [PA_W-1:0]  errAddr,
  input logic             wrEn,
  input logic [7:0]       wrAddr,
  input logic [7:0]       wrData,
  input logic [7:0]       rdAddr,
  input logic [7:0]       rdData,
  input logic             sbeFlag,
  input logic             mbeFlag,
  input logic [SYN_W-1:0] synLog,
  input logic [BLK_W-1:0] blkLog
);
  assert_first_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !sbeFlag && !mbeFlag && errStrobe && errSingle && !errMulti)
    |=> (sbeFlag && !mbeFlag && synLog == $past(errSyndrome)));

  assert_multi_overwrite_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && sbeFlag && !mbeFlag && errStrobe && errMulti)
    |=> (sbeFlag && mbeFlag && synLog == $past(errSyndrome)
         && blkLog == $past(errAddr[PA_W-1:BLK_SHIFT])));

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && mbeFlag) |=> (mbeFlag && $stable(synLog) && $stable(blkLog)));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == EA_OFF + 8'd3) |-> (rdData[7:6] == 2'b00));

  assert_clear_race_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == STS_OFF && wrData[1:0] == 2'b11
     && errStrobe && errSingle && !errMulti)
    |=> (sbeFlag && !mbeFlag));

  assert_ignore_notype_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && errStrobe && !errSingle && !errMulti)
    |=> ($stable(sbeFlag) && $stable(mbeFlag) && $stable(synLog)));
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.PA_W(PA_W), .SYN_W(SYN_W)) u_chk (
  .clk(clk), .rstN(rstN), .errStrobe(errStrobe), .errSingle(errSingle),
  .errMulti(errMulti), .errSyndrome(errSyndrome), .errAddr(errAddr),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
  .rdData(rdData), .sbeFlag(sbeFlag), .mbeFlag(mbeFlag),
  .synLog(synLog), .blkLog(blkLog)
);

// File: tb/ecc_err_logger_test.sv
`timescale 1ns/1ps
module ecc_err_logger_test;
  localparam int PA_W = 41;
  localparam int SYN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic errStrobe = 0, errSingle = 0, errMulti = 0;
  logic [SYN_W-1:0] errSyndrome = '0;
  logic [PA_W-1:0] errAddr = '0;
  logic wrEn = 0;
  logic [7:0] wrAddr = '0, wrData = '0, rdAddr = '0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic mSbe = 0, mMbe = 0;
  logic [7:0] mSyn = '0;
  logic [28:0] mBlk = '0;

  always #4 clk = ~clk;

  ecc_err_logger uut (
    .clk(clk), .rstN(rstN), .errStrobe(errStrobe), .errSingle(errSingle),
    .errMulti(errMulti), .errSyndrome(errSyndrome), .errAddr(errAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rdAddr = a;
    #0.4;
    d = rdData;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] ea;
    logic [7:0] d;
    ea = {2'b00, mBlk, 1'b0};
    rd(8'h86, d); chk({tag, " syndrome"}, d, mSyn);
    rd(8'h88, d); chk({tag, " status"}, d, {6'b0, mMbe, mSbe});
    for (int i = 0; i < 4; i++) begin
      rd(8'h8C + 8'(i), d);
      chk($sformatf("%s addr byte %0d", tag, i), d, ea[8*i +: 8]);
    end
    rd(8'h87, d); chk({tag, " unmapped R6"}, d, 8'h00);
  endtask

  // One cycle of stimulus; the model follows the written requirements.
  task automatic step(input logic st, input logic s, input logic m,
                      input logic [7:0] syn, input logic [PA_W-1:0] pa,
                      input logic wr, input logic [7:0] wa, input logic [7:0] wd);
    logic isErr, multi, canTake;
    @(negedge clk);
    errStrobe = st; errSingle = s; errMulti = m; errSyndrome = syn; errAddr = pa;
    wrEn = wr; wrAddr = wa; wrData = wd;
    @(posedge clk);
    if (wr && wa == 8'h88) begin               // R7: write one clears
      if (wd[0]) mSbe = 0;
      if (wd[1]) mMbe = 0;
    end
    isErr = st && (s || m);                    // R9
    multi = m;
    if (!mSbe && !mMbe) canTake = 1;           // R2
    else if (mMbe) canTake = 0;                // R4
    else canTake = multi;                      // R3 over logged single
    if (isErr && canTake) begin
      mSyn = syn; mBlk = pa[40:12];
      if (multi) mMbe = 1; else mSbe = 1;
    end
    #1;
    errStrobe = 0; errSingle = 0; errMulti = 0; wrEn = 0;
  endtask

  task automatic errEv(input logic s, input logic m, input logic [7:0] syn,
                       input logic [PA_W-1:0] pa);
    step(1, s, m, syn, pa, 0, 8'h00, 8'h00);
  endtask

  task automatic clearSts(input logic [7:0] bits);
    step(0, 0, 0, 8'h00, '0, 1, 8'h88, bits);
  endtask

  task automatic testReset;
    checkAll("R1 reset");
  endtask

  task automatic testFirstCapture;
    errEv(1, 0, 8'h3A, 41'h1_2345_6789A);
    checkAll("R2 first single");
    clearSts(8'h03);
    checkAll("R7 clear all");
    errEv(0, 1, 8'hC5, 41'h0_00AB_C000);
    checkAll("R2 first multi");
    clearSts(8'h03);
  endtask

  task automatic testSingleThenMulti;
    errEv(1, 0, 8'h11, 41'h0_1111_1000);
    errEv(0, 1, 8'h22, 41'h0_2222_2FFF);
    checkAll("R3 overwrite");
    errEv(0, 1, 8'h33, 41'h0_3333_3000);
    checkAll("R4 multi after multi");
    clearSts(8'h03);
  endtask

  task automatic testMultiThenSingle;
    errEv(0, 1, 8'h44, 41'h0_4444_4000);
    errEv(1, 0, 8'h55, 41'h0_5555_5000);
    checkAll("R4 single after multi");
    clearSts(8'h03);
  endtask

  task automatic testSingleThenSingle;
    errEv(1, 0, 8'h66, 41'h0_6666_6000);
    errEv(1, 0, 8'h77, 41'h0_7777_7000);
    checkAll("R4 single after single");
    clearSts(8'h03);
    errEv(1, 0, 8'h78, 41'h0_7878_7000);
    checkAll("R7 recapture after clear");
    clearSts(8'h03);
  endtask

  task automatic testPartialClear;
    errEv(1, 0, 8'h81, 41'h0_0810_0000);
    errEv(0, 1, 8'h82, 41'h0_0820_0000);
    clearSts(8'h00);
    checkAll("R7 write zero");
    clearSts(8'h01);
    checkAll("R7 clear single only");
    errEv(1, 0, 8'h83, 41'h0_0830_0000);
    checkAll("R7 still locked");
    clearSts(8'h02);
    errEv(1, 0, 8'h84, 41'h0_0840_0000);
    checkAll("R7 unlocked");
    clearSts(8'h03);
  endtask

  task automatic testClearRace;
    errEv(1, 0, 8'h91, 41'h0_0910_0000);
    step(1, 1, 0, 8'h92, 41'h0_0920_0000, 1, 8'h88, 8'h01);
    checkAll("R8 clear and single");
    step(1, 0, 1, 8'h93, 41'h0_0930_0000, 1, 8'h88, 8'h01);
    checkAll("R8 clear and multi");
    clearSts(8'h03);
  endtask

  task automatic testMalformed;
    step(1, 0, 0, 8'hA1, 41'h0_0A10_0000, 0, 8'h00, 8'h00);
    checkAll("R9 no type");
    errEv(1, 1, 8'hA2, 41'h0_0A20_0000);
    checkAll("R9 both types");
    clearSts(8'h03);
  endtask

  task automatic testReserved;
    errEv(0, 1, 8'hFF, {PA_W{1'b1}});
    checkAll("R5 all ones");
    clearSts(8'h03);
  endtask

  task automatic testOtherWrites;
    errEv(1, 0, 8'hB1, 41'h0_0B10_0000);
    step(0, 0, 0, 8'h00, '0, 1, 8'h86, 8'hFF);
    step(0, 0, 0, 8'h00, '0, 1, 8'h8C, 8'hFF);
    step(0, 0, 0, 8'h00, '0, 1, 8'h8F, 8'hFF);
    checkAll("R10 writes ignored");
    clearSts(8'h03);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    testReset();
    testFirstCapture();
    testSingleThenMulti();
    testMultiThenSingle();
    testSingleThenSingle();
    testPartialClear();
    testClearRace();
    testMalformed();
    testReserved();
    testOtherWrites();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule